// File: doc/BRIEF.md
# Belt Operand Name Map with Rescue

This block holds the logical-to-physical name map for a belt of operand positions. Each result is named by a physical tag; pushing a result puts its tag at logical position 0 and moves every older entry up by one, so the entry at the last position leaves the belt and is reported. Values are never rewritten: only the map changes. Operand read ports turn a logical position into its physical tag in the same cycle.

A rescue command renormalizes the belt in the map alone. It keeps a chosen set of entries, moves them to the front, and discards everything else. The command can select entries in two ways. A position list names entries in any order and may repeat one. A bitmap marks entries, which then land at the front in ascending position order. The same normalization is used for call and return belt handling, with no change of control flow. A rescue and a push may arrive in the same cycle.

Top module: `belt_name_map`

## Requirements
- R1: After reset every belt position is invalid and the drop report is low.
- R2: A push without a rescue places the pushed tag, valid, at position 0, and the entry that was at position i moves to position i+1 on the next clock edge.
- R3: On a push, the entry at position BELT_LEN-1 of the (normalized) belt leaves; in the cycle after the push, the drop flag is high exactly when that entry was valid, and the drop tag carries its tag.
- R4: A list rescue (`resc_mode_i` = 0) places, for k below `resc_cnt_i`, the entry at the position in list field k (bits [k*IDX_W +: IDX_W] of `resc_list_i`) at position k. The list may reorder entries and may repeat a position.
- R5: A bitmap rescue (`resc_mode_i` = 1) moves every position i whose bit i of `resc_map_i` is set to the front, in ascending position order, each at most once.
- R6: Every position not selected by a rescue is discarded. The positions after the kept entries become invalid, and a list count of zero empties the belt.
- R7: With a push and a rescue in the same cycle, the rescue applies first and the pushed tag lands at position 0 in front of the rescued entries.
- R8: Each read port returns, in the same cycle, the tag and valid flag of the map entry at its logical index. A mapping changed by a push or rescue is visible from the cycle after the command.
- R9: A rescue without a push never raises the drop report, even on a full belt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push a new result onto the belt |
| push_tag_i | input | PHYS_W | Physical tag of the pushed result |
| resc_i | input | 1 | Apply a rescue this cycle |
| resc_mode_i | input | 1 | Rescue form: 0 list, 1 bitmap |
| resc_cnt_i | input | CNT_W | Number of list entries used |
| resc_list_i | input | LIST_MAX*IDX_W | Position list, field k at bits [k*IDX_W +: IDX_W] |
| resc_map_i | input | BELT_LEN | Position bitmap, bit i selects position i |
| rd_idx_i | input | RD_PORTS*IDX_W | Logical index for each read port |
| rd_tag_o | output | RD_PORTS*PHYS_W | Physical tag for each read port |
| rd_vld_o | output | RD_PORTS | Valid flag for each read port |
| map_tag_o | output | BELT_LEN*PHYS_W | Full map, entry i at bits [i*PHYS_W +: PHYS_W] |
| map_vld_o | output | BELT_LEN | Valid flag per position |
| drop_vld_o | output | 1 | An entry left the belt on the last push |
| drop_tag_o | output | PHYS_W | Tag of the entry that left |

## Verification
The bench builds the block with a belt of 8 positions, 8-bit tags, a list of up to 4 entries and two read ports. With only 8 positions, ten pushes fill the belt and force entries off the end, and a full-belt bitmap rescue is reached in a few cycles, so the drop path and every bitmap position are exercised. A list of 4 with 3-bit indices lets the bench name the same position several times and pick the oldest entry, and the two read ports are swept across valid and invalid positions right after each command.

// File: rtl/belt_pkg.sv
package belt_pkg;

   typedef enum logic {
      RESC_LIST   = 1'b0,
      RESC_BITMAP = 1'b1
   } resc_mode_e;

   function automatic bit belt_len_ok(input int len);
      return (len == 8) || (len == 16) || (len == 32) || (len == 64);
   endfunction

endpackage

// File: rtl/belt_list_gather.sv
module belt_list_gather #(
   parameter int BELT_LEN = 8,
   parameter int PHYS_W   = 8,
   parameter int LIST_MAX = 4,
   localparam int IDX_W   = $clog2(BELT_LEN),
   localparam int CNT_W   = $clog2(LIST_MAX + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [PHYS_W-1:0]         cur_tag [BELT_LEN],
   input  logic [BELT_LEN-1:0]       cur_vld,
   input  logic [CNT_W-1:0]          cnt,
   input  logic [LIST_MAX*IDX_W-1:0] list,
   output logic [PHYS_W-1:0]         out_tag [BELT_LEN],
   output logic [BELT_LEN-1:0]       out_vld
);

   always_comb begin
      for (int j = 0; j < BELT_LEN; j++) begin
         out_tag[j] = '0;
      end
      out_vld = '0;
      for (int k = 0; k < LIST_MAX; k++) begin
         if (CNT_W'(k) < cnt) begin
            out_tag[k] = cur_tag[list[k*IDX_W +: IDX_W]];
            out_vld[k] = cur_vld[list[k*IDX_W +: IDX_W]];
         end
      end
   end

   // R6: a list never yields more valid entries than its count
   a_r6_list_bound: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_vld) <= int'(cnt));

   // R4: first list slot mirrors the entry it names
   a_r4_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> (out_vld[0] == cur_vld[list[IDX_W-1:0]]));

endmodule

// File: rtl/belt_bitmap_pack.sv
module belt_bitmap_pack #(
   parameter int BELT_LEN = 8,
   parameter int PHYS_W   = 8,
   localparam int IDX_W   = $clog2(BELT_LEN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PHYS_W-1:0]   cur_tag [BELT_LEN],
   input  logic [BELT_LEN-1:0] cur_vld,
   input  logic [BELT_LEN-1:0] sel,
   output logic [PHYS_W-1:0]   out_tag [BELT_LEN],
   output logic [BELT_LEN-1:0] out_vld
);

   logic [IDX_W:0] dst;

   always_comb begin
      for (int j = 0; j < BELT_LEN; j++) begin
         out_tag[j] = '0;
      end
      out_vld = '0;
      dst     = '0;
      for (int i = 0; i < BELT_LEN; i++) begin
         if (sel[i]) begin
            out_tag[dst[IDX_W-1:0]] = cur_tag[i];
            out_vld[dst[IDX_W-1:0]] = cur_vld[i];
            dst = dst + 1'b1;
         end
      end
   end

   // R5: every marked valid entry survives, nothing else does
   a_r5_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_vld) == $countones(sel & cur_vld));

   // R6: an empty bitmap discards the whole belt
   a_r6_empty_map: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> (out_vld == '0));

endmodule

// File: rtl/belt_read_port.sv
module belt_read_port #(
   parameter int BELT_LEN = 8,
   parameter int PHYS_W   = 8,
   localparam int IDX_W   = $clog2(BELT_LEN)
) (
   input  logic [IDX_W-1:0]    idx,
   input  logic [PHYS_W-1:0]   map_tag [BELT_LEN],
   input  logic [BELT_LEN-1:0] map_vld,
   output logic [PHYS_W-1:0]   tag,
   output logic                vld
);

   always_comb begin
      tag = map_tag[idx];
      vld = map_vld[idx];
   end

endmodule

// File: rtl/belt_name_map.sv
module belt_name_map
   import belt_pkg::*;
#(
   parameter int BELT_LEN = 8,
   parameter int PHYS_W   = 8,
   parameter int LIST_MAX = 4,
   parameter int RD_PORTS = 2,
   localparam int IDX_W   = $clog2(BELT_LEN),
   localparam int CNT_W   = $clog2(LIST_MAX + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push_i,
   input  logic [PHYS_W-1:0]         push_tag_i,
   input  logic                      resc_i,
   input  logic                      resc_mode_i,
   input  logic [CNT_W-1:0]          resc_cnt_i,
   input  logic [LIST_MAX*IDX_W-1:0] resc_list_i,
   input  logic [BELT_LEN-1:0]       resc_map_i,
   input  logic [RD_PORTS*IDX_W-1:0] rd_idx_i,
   output logic [RD_PORTS*PHYS_W-1:0] rd_tag_o,
   output logic [RD_PORTS-1:0]       rd_vld_o,
   output logic [BELT_LEN*PHYS_W-1:0] map_tag_o,
   output logic [BELT_LEN-1:0]       map_vld_o,
   output logic                      drop_vld_o,
   output logic [PHYS_W-1:0]         drop_tag_o
);

   // elaboration-time parameter checks
   if (!belt_len_ok(BELT_LEN)) begin : g_bad_len
      $error("belt_name_map: BELT_LEN must be 8, 16, 32 or 64");
   end
   if (LIST_MAX < 1 || LIST_MAX > BELT_LEN) begin : g_bad_list
      $error("belt_name_map: LIST_MAX must lie in 1..BELT_LEN");
   end
   if (PHYS_W < 1 || RD_PORTS < 1) begin : g_bad_width
      $error("belt_name_map: PHYS_W and RD_PORTS must be positive");
   end

   logic [PHYS_W-1:0]   map_tag_q [BELT_LEN];
   logic [BELT_LEN-1:0] map_vld_q;

   logic [PHYS_W-1:0]   lst_tag [BELT_LEN];
   logic [BELT_LEN-1:0] lst_vld;
   logic [PHYS_W-1:0]   bmp_tag [BELT_LEN];
   logic [BELT_LEN-1:0] bmp_vld;
   logic [PHYS_W-1:0]   norm_tag [BELT_LEN];
   logic [BELT_LEN-1:0] norm_vld;
   logic [PHYS_W-1:0]   nxt_tag [BELT_LEN];
   logic [BELT_LEN-1:0] nxt_vld;

   belt_list_gather #(
      .BELT_LEN (BELT_LEN),
      .PHYS_W   (PHYS_W),
      .LIST_MAX (LIST_MAX)
   ) i_gather (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur_tag (map_tag_q),
      .cur_vld (map_vld_q),
      .cnt     (resc_cnt_i),
      .list    (resc_list_i),
      .out_tag (lst_tag),
      .out_vld (lst_vld)
   );

   belt_bitmap_pack #(
      .BELT_LEN (BELT_LEN),
      .PHYS_W   (PHYS_W)
   ) i_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur_tag (map_tag_q),
      .cur_vld (map_vld_q),
      .sel     (resc_map_i),
      .out_tag (bmp_tag),
      .out_vld (bmp_vld)
   );

   // rescue first, then push on top of the normalized belt
   always_comb begin
      for (int i = 0; i < BELT_LEN; i++) begin
         if (!resc_i) begin
            norm_tag[i] = map_tag_q[i];
            norm_vld[i] = map_vld_q[i];
         end else if (resc_mode_e'(resc_mode_i) == RESC_BITMAP) begin
            norm_tag[i] = bmp_tag[i];
            norm_vld[i] = bmp_vld[i];
         end else begin
            norm_tag[i] = lst_tag[i];
            norm_vld[i] = lst_vld[i];
         end
      end
   end

   always_comb begin
      if (push_i) begin
         nxt_tag[0] = push_tag_i;
         nxt_vld[0] = 1'b1;
         for (int i = 1; i < BELT_LEN; i++) begin
            nxt_tag[i] = norm_tag[i-1];
            nxt_vld[i] = norm_vld[i-1];
         end
      end else begin
         for (int i = 0; i < BELT_LEN; i++) begin
            nxt_tag[i] = norm_tag[i];
         end
         nxt_vld = norm_vld;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < BELT_LEN; i++) begin
            map_tag_q[i] <= '0;
         end
         map_vld_q  <= '0;
         drop_vld_o <= 1'b0;
         drop_tag_o <= '0;
      end else begin
         for (int i = 0; i < BELT_LEN; i++) begin
            map_tag_q[i] <= nxt_tag[i];
         end
         map_vld_q  <= nxt_vld;
         drop_vld_o <= push_i & norm_vld[BELT_LEN-1];
         drop_tag_o <= norm_tag[BELT_LEN-1];
      end
   end

   for (genvar g = 0; g < BELT_LEN; g++) begin : g_map_out
      assign map_tag_o[g*PHYS_W +: PHYS_W] = map_tag_q[g];
   end
   assign map_vld_o = map_vld_q;

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      belt_read_port #(
         .BELT_LEN (BELT_LEN),
         .PHYS_W   (PHYS_W)
      ) i_port (
         .idx     (rd_idx_i[p*IDX_W +: IDX_W]),
         .map_tag (map_tag_q),
         .map_vld (map_vld_q),
         .tag     (rd_tag_o[p*PHYS_W +: PHYS_W]),
         .vld     (rd_vld_o[p])
      );
   end

   // R2: pushed tag appears valid at the front
   a_r2_push_front: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> (map_vld_o[0] && map_tag_o[PHYS_W-1:0] == $past(push_tag_i)));

   // R2: plain push moves the front entry to position 1
   a_r2_shift_one: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !resc_i) |=> (map_vld_o[1] == $past(map_vld_o[0]) &&
         (!map_vld_o[1] || map_tag_o[2*PHYS_W-1:PHYS_W] == $past(map_tag_o[PHYS_W-1:0]))));

   // R9: no push, no drop report
   a_r9_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !push_i |=> !drop_vld_o);

   // R5: bitmap rescue alone keeps exactly the marked valid entries
   a_r5_bitmap_count: assert property (@(posedge clk) disable iff (!rst_n)
      (resc_i && resc_mode_i && !push_i) |=>
         ($countones(map_vld_o) == $past($countones(resc_map_i & map_vld_o))));

   // R7: combined push and rescue leaves the pushed tag at the front
   a_r7_push_wins_front: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && resc_i) |=> (map_tag_o[PHYS_W-1:0] == $past(push_tag_i)));

   // R3: a drop only follows a full belt
   a_r3_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !resc_i && !map_vld_o[BELT_LEN-1]) |=> !drop_vld_o);

endmodule

// File: tb/test_belt_name_map.sv
`timescale 1ns/1ps
module test_belt_name_map;

   localparam int BL = 8;
   localparam int PW = 8;
   localparam int LM = 4;
   localparam int RP = 2;
   localparam int IW = 3;
   localparam int CW = 3;

   typedef struct packed {
      logic          push;
      logic [PW-1:0] tag;
      logic          resc;
      logic          mode;
      logic [CW-1:0] cnt;
      logic [LM*IW-1:0] list;
      logic [BL-1:0] map;
      logic [3:0]    exp_cnt;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'h10, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd1},
      '{1'b1, 8'h11, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd2},
      '{1'b1, 8'h12, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd3},
      '{1'b1, 8'h13, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd4},
      '{1'b1, 8'h14, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd5},
      '{1'b1, 8'h15, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd6},
      '{1'b1, 8'h16, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd7},
      '{1'b1, 8'h17, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd8},
      '{1'b1, 8'h18, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd8},
      '{1'b0, 8'h00, 1'b1, 1'b0, 3'd3, 12'h082, 8'h00, 4'd3},
      '{1'b1, 8'h19, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd4},
      '{1'b1, 8'h1A, 1'b1, 1'b1, 3'd0, 12'h000, 8'h0B, 4'd4},
      '{1'b1, 8'h1B, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd5},
      '{1'b0, 8'h00, 1'b1, 1'b1, 3'd0, 12'h000, 8'hFF, 4'd5},
      '{1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 12'h000, 8'h00, 4'd0},
      '{1'b1, 8'h1C, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              push_i = 1'b0;
   logic [PW-1:0]     push_tag_i = '0;
   logic              resc_i = 1'b0;
   logic              resc_mode_i = 1'b0;
   logic [CW-1:0]     resc_cnt_i = '0;
   logic [LM*IW-1:0]  resc_list_i = '0;
   logic [BL-1:0]     resc_map_i = '0;
   logic [RP*IW-1:0]  rd_idx_i = '0;
   logic [RP*PW-1:0]  rd_tag_o;
   logic [RP-1:0]     rd_vld_o;
   logic [BL*PW-1:0]  map_tag_o;
   logic [BL-1:0]     map_vld_o;
   logic              drop_vld_o;
   logic [PW-1:0]     drop_tag_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [PW-1:0] m_tag [BL];
   logic          m_vld [BL];

   always #2 clk = ~clk;

   belt_name_map #(
      .BELT_LEN (BL),
      .PHYS_W   (PW),
      .LIST_MAX (LM),
      .RD_PORTS (RP)
   ) i_belt_name_map (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_i),
      .push_tag_i  (push_tag_i),
      .resc_i      (resc_i),
      .resc_mode_i (resc_mode_i),
      .resc_cnt_i  (resc_cnt_i),
      .resc_list_i (resc_list_i),
      .resc_map_i  (resc_map_i),
      .rd_idx_i    (rd_idx_i),
      .rd_tag_o    (rd_tag_o),
      .rd_vld_o    (rd_vld_o),
      .map_tag_o   (map_tag_o),
      .map_vld_o   (map_vld_o),
      .drop_vld_o  (drop_vld_o),
      .drop_tag_o  (drop_tag_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < BL; i++) begin
         m_tag[i] = '0;
         m_vld[i] = 1'b0;
      end
   endtask

   function automatic logic [BL-1:0] model_vld_vec();
      logic [BL-1:0] v;
      for (int i = 0; i < BL; i++) v[i] = m_vld[i];
      return v;
   endfunction

   // reference: rescue on a queue copy, then push
   task automatic model_step(input vec_t v, output logic e_drop, output logic [PW-1:0] e_dtag);
      logic [PW-1:0] n_tag [BL];
      logic          n_vld [BL];
      int            j;
      for (int i = 0; i < BL; i++) begin
         n_tag[i] = m_tag[i];
         n_vld[i] = m_vld[i];
      end
      if (v.resc) begin
         for (int i = 0; i < BL; i++) begin
            n_tag[i] = '0;
            n_vld[i] = 1'b0;
         end
         if (v.mode) begin
            j = 0;
            for (int i = 0; i < BL; i++) begin
               if (v.map[i]) begin
                  n_tag[j] = m_tag[i];
                  n_vld[j] = m_vld[i];
                  j++;
               end
            end
         end else begin
            for (int k = 0; k < int'(v.cnt); k++) begin
               n_tag[k] = m_tag[v.list[k*IW +: IW]];
               n_vld[k] = m_vld[v.list[k*IW +: IW]];
            end
         end
      end
      e_drop = v.push & n_vld[BL-1];
      e_dtag = n_tag[BL-1];
      if (v.push) begin
         for (int i = BL-1; i > 0; i--) begin
            m_tag[i] = n_tag[i-1];
            m_vld[i] = n_vld[i-1];
         end
         m_tag[0] = v.tag;
         m_vld[0] = 1'b1;
      end else begin
         for (int i = 0; i < BL; i++) begin
            m_tag[i] = n_tag[i];
            m_vld[i] = n_vld[i];
         end
      end
   endtask

   task automatic apply(input vec_t v, input int n, input bit use_cnt);
      logic          e_drop;
      logic [PW-1:0] e_dtag;
      bit            ok;
      string         req;
      logic [IW-1:0] i0;
      logic [IW-1:0] i1;
      @(negedge clk);
      push_i      = v.push;
      push_tag_i  = v.tag;
      resc_i      = v.resc;
      resc_mode_i = v.mode;
      resc_cnt_i  = v.cnt;
      resc_list_i = v.list;
      resc_map_i  = v.map;
      model_step(v, e_drop, e_dtag);
      @(negedge clk);
      push_i = 1'b0;
      resc_i = 1'b0;
      if (v.push && v.resc) req = "R7";
      else if (v.resc) req = v.mode ? "R5" : "R4";
      else req = "R2";
      ok = (map_vld_o == model_vld_vec());
      for (int i = 0; i < BL; i++) begin
         if (m_vld[i] && map_tag_o[i*PW +: PW] != m_tag[i]) ok = 1'b0;
      end
      chk(ok, req, {map_vld_o, map_tag_o}, {model_vld_vec(), 56'h0});
      if (use_cnt)
         chk($countones(map_vld_o) == int'(v.exp_cnt), "R6",
             64'($countones(map_vld_o)), 64'(v.exp_cnt));
      chk(drop_vld_o == e_drop && (!e_drop || drop_tag_o == e_dtag),
          v.push ? "R3" : "R9", {drop_vld_o, drop_tag_o}, {e_drop, e_dtag});
      i0 = IW'(n % BL);
      i1 = IW'((BL - 1) - (n % BL));
      rd_idx_i = {i1, i0};
      #1;
      chk(rd_vld_o[0] == m_vld[i0] && (!m_vld[i0] || rd_tag_o[PW-1:0] == m_tag[i0]) &&
          rd_vld_o[1] == m_vld[i1] && (!m_vld[i1] || rd_tag_o[2*PW-1:PW] == m_tag[i1]),
          "R8", {rd_vld_o, rd_tag_o}, 64'(n));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      vec_t d;
      model_clear();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(map_vld_o == '0, "R1", 64'(map_vld_o), 64'h0);
      chk(drop_vld_o == 1'b0, "R1", 64'(drop_vld_o), 64'h0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         apply(VECS[v], v, 1'b1);
      end

      // fill to full again (R2, R3)
      for (int t = 0; t < 7; t++) begin
         d = '{1'b1, 8'h20 + PW'(t), 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd0};
         apply(d, t, 1'b0);
      end
      // R9: bitmap rescue on a full belt keeps all, no drop
      d = '{1'b0, 8'h00, 1'b1, 1'b1, 3'd0, 12'h000, 8'hFF, 4'd8};
      apply(d, 3, 1'b1);
      // R7/R4: push with list repeating the oldest entry four times
      d = '{1'b1, 8'h27, 1'b1, 1'b0, 3'd4, 12'hFFF, 8'h00, 4'd5};
      apply(d, 5, 1'b1);
      // R5: bitmap selecting only invalid tail positions empties belt
      d = '{1'b0, 8'h00, 1'b1, 1'b1, 3'd0, 12'h000, 8'hE0, 4'd0};
      apply(d, 6, 1'b1);
      // R6: list of two pulling one valid, one invalid position
      d = '{1'b1, 8'h30, 1'b0, 1'b0, 3'd0, 12'h000, 8'h00, 4'd1};
      apply(d, 0, 1'b1);
      d = '{1'b0, 8'h00, 1'b1, 1'b0, 3'd2, 12'h028, 8'h00, 4'd1};
      apply(d, 1, 1'b1);

      // R1: reset in mid run clears the belt
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      model_clear();
      chk(map_vld_o == '0 && drop_vld_o == 1'b0, "R1",
          {map_vld_o, drop_vld_o}, 64'h0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule